// File: doc/BRIEF.md
# Indexed Effective-Address Generator

This unit forms the 16-bit operand address for a processor's indexed addressing modes. From one addressing postbyte, up to two extension bytes and the current register values, it chooses a base, which is one of four index/stack registers or the program counter. It then picks a signed offset and adds the two. The offset can be embedded in the postbyte, taken from the extension bytes, or taken from an accumulator. The unit also reports how many extension bytes the mode consumed. It flags modes that ask for one level of indirection, where the computed address holds a pointer to the real operand, and it flags encodings it cannot serve.

When the surrounding core executes a load-effective-address instruction, it raises `lea_i` with a destination select. The computed sum is then offered for write-back to that register instead of being used for a memory access. This lets software do 16-bit add and subtract through the address path, for example setting U to X minus 1234. Sequencing of the actual memory reads, including the pointer fetch for indirect modes, belongs to the caller. The result appears one clock after the request.

Top module: `idx_ea_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request completes, `valid_o`, `ea_o`, `indirect_o`, `illegal_o`, `ext_len_o`, `lea_we_o` and `lea_dst_o` are all zero.
- R2: A postbyte with bit 7 = 0 is the short form. Bits 6:5 pick the base (00 X, 01 Y, 10 U, 11 S) and bits 4:0 are a two's-complement offset. The result is `ea_o` = base + sign-extended offset, with `ext_len_o` = 0, `indirect_o` = 0 and `illegal_o` = 0.
- R3: A postbyte with bit 7 = 1 takes its base from bits 6:5 as in R2 and its mode from bits 3:0. Mode 0000 adds nothing and uses 0 extension bytes. Mode 0001 adds the sign-extended first extension byte `ext_i[15:8]` and uses 1 byte. Mode 0010 adds the 16-bit `ext_i` and uses 2 bytes.
- R4: Modes 0011 and 0100 add accumulator A or B, sign-extended from 8 bits. Mode 0101 adds D = {A, B}, with A as the upper byte. All three use 0 extension bytes.
- R5: Mode 0110 adds the sign-extended `ext_i[15:8]` to `reg_pc_i` and uses 1 byte. Mode 0111 adds `ext_i` to `reg_pc_i` and uses 2 bytes. Bits 6:5 are ignored in both.
- R6: In the long form, postbyte bit 4 = 1 with a legal mode and no LEA sets `indirect_o` = 1, while `ea_o` is the pointer location computed as in R3 to R5.
- R7: With `lea_i` = 1 and a legal, non-indirect request, `lea_we_o` = 1, `lea_dst_o` = `lea_dst_i` (00 X, 01 Y, 10 U, 11 S) and `ea_o` holds the value to write, while `indirect_o` = 0. An LEA request with bit 4 = 1 in the long form gives `illegal_o` = 1 and `lea_we_o` = 0.
- R8: Long-form modes 1000 to 1111 give `illegal_o` = 1, `indirect_o` = 0, `lea_we_o` = 0 and `ext_len_o` = 0.
- R9: Outputs for a request sampled with `valid_i` = 1 appear after the next rising edge with `valid_o` = 1. A cycle with `valid_i` = 0 gives `valid_o` = 0, `lea_we_o` = 0, and leaves `ea_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Request strobe |
| postbyte_i | input | 8 | Addressing postbyte |
| ext_i | input | 16 | Extension bytes, first byte in bits 15:8 |
| lea_i | input | 1 | Request is a load-effective-address |
| lea_dst_i | input | 2 | LEA destination register select |
| reg_x_i | input | 16 | X register value |
| reg_y_i | input | 16 | Y register value |
| reg_u_i | input | 16 | U register value |
| reg_s_i | input | 16 | S register value |
| reg_pc_i | input | 16 | Program counter base for relative modes |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| valid_o | output | 1 | Result valid |
| ea_o | output | 16 | Effective address or LEA value |
| indirect_o | output | 1 | Pointer fetch requested |
| illegal_o | output | 1 | Encoding cannot be served |
| ext_len_o | output | 2 | Extension bytes consumed (0, 1 or 2) |
| lea_we_o | output | 1 | LEA write-back enable |
| lea_dst_o | output | 2 | LEA destination register select |

## Verification
A wrong base or offset selection shows up as an `ea_o` that differs from the hand-computed sum one clock after the request. The register values are chosen far apart, so a wrong base cannot coincide with the right one. Decode mistakes show up in the same cycle as a wrong `ext_len_o`, a missing or spurious `indirect_o`, or a write-back enable raised on an illegal or indirect request. A stale result register is caught at the port in the first idle cycle after a request, through `valid_o` and an `ea_o` that has changed.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int SHORT_W = 5;
    localparam int LEN_W   = 2;
    localparam int SEL_W   = 2;

    typedef enum logic [2:0] {
        BASE_X  = 3'd0,
        BASE_Y  = 3'd1,
        BASE_U  = 3'd2,
        BASE_S  = 3'd3,
        BASE_PC = 3'd4
    } base_sel_t;

    typedef enum logic [2:0] {
        OFF_NONE = 3'd0,
        OFF_S5   = 3'd1,
        OFF_8    = 3'd2,
        OFF_16   = 3'd3,
        OFF_A    = 3'd4,
        OFF_B    = 3'd5,
        OFF_D    = 3'd6
    } off_kind_t;

    typedef struct packed {
        base_sel_t        base_sel;
        off_kind_t        off_kind;
        logic             ind;
        logic [LEN_W-1:0] ext_len;
        logic             illegal;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] ea;
        logic              ind;
        logic              illegal;
        logic [LEN_W-1:0]  ext_len;
        logic              lea_we;
        logic [SEL_W-1:0]  lea_dst;
    } res_t;
endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
    import idx_ea_pkg::*;
(
    input  logic [7:0] postbyte_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o          = '0;
        dec_o.base_sel = base_sel_t'({1'b0, postbyte_i[6:5]});
        if (!postbyte_i[7]) begin
            dec_o.off_kind = OFF_S5;
            dec_o.ext_len  = 2'd0;
            dec_o.ind      = 1'b0;
        end else begin
            dec_o.ind = postbyte_i[4];
            case (postbyte_i[3:0])
                4'b0000: begin dec_o.off_kind = OFF_NONE; dec_o.ext_len = 2'd0; end
                4'b0001: begin dec_o.off_kind = OFF_8;    dec_o.ext_len = 2'd1; end
                4'b0010: begin dec_o.off_kind = OFF_16;   dec_o.ext_len = 2'd2; end
                4'b0011: begin dec_o.off_kind = OFF_A;    dec_o.ext_len = 2'd0; end
                4'b0100: begin dec_o.off_kind = OFF_B;    dec_o.ext_len = 2'd0; end
                4'b0101: begin dec_o.off_kind = OFF_D;    dec_o.ext_len = 2'd0; end
                4'b0110: begin
                    dec_o.off_kind = OFF_8;
                    dec_o.ext_len  = 2'd1;
                    dec_o.base_sel = BASE_PC;
                end
                4'b0111: begin
                    dec_o.off_kind = OFF_16;
                    dec_o.ext_len  = 2'd2;
                    dec_o.base_sel = BASE_PC;
                end
                default: begin
                    dec_o.off_kind = OFF_NONE;
                    dec_o.ext_len  = 2'd0;
                    dec_o.ind      = 1'b0;
                    dec_o.illegal  = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/idx_ea_offset.sv
module idx_ea_offset
    import idx_ea_pkg::*;
(
    input  off_kind_t             kind_i,
    input  logic [SHORT_W-1:0]    short_i,
    input  logic [ADDR_W-1:0]     ext_i,
    input  logic [BYTE_W-1:0]     acc_a_i,
    input  logic [BYTE_W-1:0]     acc_b_i,
    output logic [ADDR_W-1:0]     off_o
);
    localparam int SHORT_PAD = ADDR_W - SHORT_W;
    localparam int BYTE_PAD  = ADDR_W - BYTE_W;

    logic [BYTE_W-1:0] first_byte;
    assign first_byte = ext_i[ADDR_W-1 -: BYTE_W];

    always_comb begin
        case (kind_i)
            OFF_S5:  off_o = {{SHORT_PAD{short_i[SHORT_W-1]}}, short_i};
            OFF_8:   off_o = {{BYTE_PAD{first_byte[BYTE_W-1]}}, first_byte};
            OFF_16:  off_o = ext_i;
            OFF_A:   off_o = {{BYTE_PAD{acc_a_i[BYTE_W-1]}}, acc_a_i};
            OFF_B:   off_o = {{BYTE_PAD{acc_b_i[BYTE_W-1]}}, acc_b_i};
            OFF_D:   off_o = {acc_a_i, acc_b_i};
            default: off_o = '0;
        endcase
    end
endmodule

// File: rtl/idx_ea_base.sv
module idx_ea_base
    import idx_ea_pkg::*;
(
    input  base_sel_t         sel_i,
    input  logic [ADDR_W-1:0] reg_x_i,
    input  logic [ADDR_W-1:0] reg_y_i,
    input  logic [ADDR_W-1:0] reg_u_i,
    input  logic [ADDR_W-1:0] reg_s_i,
    input  logic [ADDR_W-1:0] reg_pc_i,
    output logic [ADDR_W-1:0] base_o
);
    localparam int NREG = 5;
    logic [ADDR_W-1:0] bank [NREG];

    assign bank[0] = reg_x_i;
    assign bank[1] = reg_y_i;
    assign bank[2] = reg_u_i;
    assign bank[3] = reg_s_i;
    assign bank[4] = reg_pc_i;

    always_comb begin
        base_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(sel_i) == i) base_o = bank[i];
        end
    end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [7:0]        postbyte_i,
    input  logic [15:0]       ext_i,
    input  logic              lea_i,
    input  logic [1:0]        lea_dst_i,
    input  logic [15:0]       reg_x_i,
    input  logic [15:0]       reg_y_i,
    input  logic [15:0]       reg_u_i,
    input  logic [15:0]       reg_s_i,
    input  logic [15:0]       reg_pc_i,
    input  logic [7:0]        acc_a_i,
    input  logic [7:0]        acc_b_i,
    output logic              valid_o,
    output logic [15:0]       ea_o,
    output logic              indirect_o,
    output logic              illegal_o,
    output logic [1:0]        ext_len_o,
    output logic              lea_we_o,
    output logic [1:0]        lea_dst_o
);
    dec_t              dec;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    res_t              st_d, st_q;
    logic              bad_now;

    idx_ea_decode u_dec (
        .postbyte_i (postbyte_i),
        .dec_o      (dec)
    );

    idx_ea_base u_base (
        .sel_i    (dec.base_sel),
        .reg_x_i  (reg_x_i),
        .reg_y_i  (reg_y_i),
        .reg_u_i  (reg_u_i),
        .reg_s_i  (reg_s_i),
        .reg_pc_i (reg_pc_i),
        .base_o   (base)
    );

    idx_ea_offset u_off (
        .kind_i  (dec.off_kind),
        .short_i (postbyte_i[SHORT_W-1:0]),
        .ext_i   (ext_i),
        .acc_a_i (acc_a_i),
        .acc_b_i (acc_b_i),
        .off_o   (off)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = valid_i;
        st_d.lea_we = 1'b0;
        bad_now     = dec.illegal | (lea_i & dec.ind);
        if (valid_i) begin
            st_d.ea      = base + off;
            st_d.illegal = bad_now;
            st_d.ind     = dec.ind & ~lea_i & ~bad_now;
            st_d.ext_len = dec.ext_len;
            st_d.lea_we  = lea_i & ~bad_now;
            st_d.lea_dst = lea_dst_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o    = st_q.valid;
    assign ea_o       = st_q.ea;
    assign indirect_o = st_q.ind;
    assign illegal_o  = st_q.illegal;
    assign ext_len_o  = st_q.ext_len;
    assign lea_we_o   = st_q.lea_we;
    assign lea_dst_o  = st_q.lea_dst;

    assert_short_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !postbyte_i[7]) |=> (ext_len_o == 2'd0 && !indirect_o && !illegal_o));

    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (ext_len_o != 2'd3));

    assert_wb_not_ind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lea_we_o && indirect_o));

    assert_lea_ind_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lea_i && postbyte_i[7] && postbyte_i[4]) |=> (illegal_o && !lea_we_o));

    assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && postbyte_i[7] && postbyte_i[3]) |=> (illegal_o && !indirect_o && !lea_we_o));

    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!indirect_o && !lea_we_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && !lea_we_o && $stable(ea_o)));
endmodule

// File: tb/sim_idx_ea_gen.sv
module sim_idx_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  postbyte_i = '0;
    logic [15:0] ext_i = '0;
    logic        lea_i = 1'b0;
    logic [1:0]  lea_dst_i = '0;
    logic [15:0] reg_x_i = 16'h1000;
    logic [15:0] reg_y_i = 16'h2000;
    logic [15:0] reg_u_i = 16'h4000;
    logic [15:0] reg_s_i = 16'h8000;
    logic [15:0] reg_pc_i = 16'hC000;
    logic [7:0]  acc_a_i = '0;
    logic [7:0]  acc_b_i = '0;
    logic        valid_o, indirect_o, illegal_o, lea_we_o;
    logic [15:0] ea_o;
    logic [1:0]  ext_len_o, lea_dst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    idx_ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .postbyte_i(postbyte_i),
        .ext_i(ext_i), .lea_i(lea_i), .lea_dst_i(lea_dst_i),
        .reg_x_i(reg_x_i), .reg_y_i(reg_y_i), .reg_u_i(reg_u_i),
        .reg_s_i(reg_s_i), .reg_pc_i(reg_pc_i), .acc_a_i(acc_a_i),
        .acc_b_i(acc_b_i), .valid_o(valid_o), .ea_o(ea_o),
        .indirect_o(indirect_o), .illegal_o(illegal_o), .ext_len_o(ext_len_o),
        .lea_we_o(lea_we_o), .lea_dst_o(lea_dst_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next rising
    // edge and sampled at the falling edge after it.
    task automatic issue(input logic [7:0] pb, input logic [15:0] ext,
                         input logic lea, input logic [1:0] dst);
        @(negedge clk);
        postbyte_i = pb; ext_i = ext; lea_i = lea; lea_dst_i = dst; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; lea_i = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [15:0] ea,
                              input logic [1:0] len, input logic ind, input logic ill);
        chk(req, "valid", {15'd0, valid_o}, 16'd1);
        chk(req, "ea", ea_o, ea);
        chk(req, "ext_len", {14'd0, ext_len_o}, {14'd0, len});
        chk(req, "indirect", {15'd0, indirect_o}, {15'd0, ind});
        chk(req, "illegal", {15'd0, illegal_o}, {15'd0, ill});
    endtask

    task automatic t_reset_R1;
        chk("R1", "valid", {15'd0, valid_o}, 16'd0);
        chk("R1", "ea", ea_o, 16'd0);
        chk("R1", "flags", {12'd0, indirect_o, illegal_o, lea_we_o, 1'b0}, 16'd0);
        chk("R1", "len/dst", {12'd0, ext_len_o, lea_dst_o}, 16'd0);
    endtask

    task automatic t_short_R2;
        issue(8'b0_10_10000, 16'hFFFF, 1'b0, 2'd0);   // U - 16
        expect_res("R2", 16'h3FF0, 2'd0, 1'b0, 1'b0);
        issue(8'b0_00_01111, 16'h0000, 1'b0, 2'd0);   // X + 15
        expect_res("R2", 16'h100F, 2'd0, 1'b0, 1'b0);
        issue(8'b0_11_11111, 16'h0000, 1'b0, 2'd0);   // S - 1, bit 4 set but short form
        expect_res("R2", 16'h7FFF, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_const_R3;
        issue(8'b1_01_0_0000, 16'h1234, 1'b0, 2'd0);  // Y
        expect_res("R3", 16'h2000, 2'd0, 1'b0, 1'b0);
        issue(8'b1_11_0_0001, 16'h8077, 1'b0, 2'd0);  // S - 128
        expect_res("R3", 16'h7F80, 2'd1, 1'b0, 1'b0);
        issue(8'b1_01_0_0010, 16'h0345, 1'b0, 2'd0);  // Y + 0x0345
        expect_res("R3", 16'h2345, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_acc_R4;
        acc_a_i = 8'hF0; acc_b_i = 8'h7F;
        issue(8'b1_00_0_0011, 16'h0000, 1'b0, 2'd0);  // X + A(-16)
        expect_res("R4", 16'h0FF0, 2'd0, 1'b0, 1'b0);
        issue(8'b1_10_0_0100, 16'h0000, 1'b0, 2'd0);  // U + B(127)
        expect_res("R4", 16'h407F, 2'd0, 1'b0, 1'b0);
        acc_a_i = 8'h12; acc_b_i = 8'h34;
        issue(8'b1_01_0_0101, 16'hFFFF, 1'b0, 2'd0);  // Y + D
        expect_res("R4", 16'h3234, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_pcrel_R5;
        issue(8'b1_11_0_0110, 16'hFE00, 1'b0, 2'd0);  // PC - 2
        expect_res("R5", 16'hBFFE, 2'd1, 1'b0, 1'b0);
        issue(8'b1_01_0_0111, 16'h0100, 1'b0, 2'd0);  // PC + 256
        expect_res("R5", 16'hC100, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_indirect_R6;
        issue(8'b1_00_1_0001, 16'h0500, 1'b0, 2'd0);  // [X + 5]
        expect_res("R6", 16'h1005, 2'd1, 1'b1, 1'b0);
        issue(8'b1_11_1_0111, 16'h0010, 1'b0, 2'd0);  // [PC + 16]
        expect_res("R6", 16'hC010, 2'd2, 1'b1, 1'b0);
    endtask

    task automatic t_lea_R7;
        issue(8'b1_00_0_0010, 16'hFB2E, 1'b1, 2'd2);  // U = X - 1234
        expect_res("R7", 16'h0B2E, 2'd2, 1'b0, 1'b0);
        chk("R7", "lea_we", {15'd0, lea_we_o}, 16'd1);
        chk("R7", "lea_dst", {14'd0, lea_dst_o}, 16'd2);
        issue(8'b1_00_1_0000, 16'h0000, 1'b1, 2'd1);  // LEA with indirect
        chk("R7", "illegal", {15'd0, illegal_o}, 16'd1);
        chk("R7", "lea_we", {15'd0, lea_we_o}, 16'd0);
        chk("R7", "indirect", {15'd0, indirect_o}, 16'd0);
    endtask

    task automatic t_reserved_R8;
        issue(8'b1_00_1_1010, 16'h1234, 1'b1, 2'd0);
        chk("R8", "illegal", {15'd0, illegal_o}, 16'd1);
        chk("R8", "indirect", {15'd0, indirect_o}, 16'd0);
        chk("R8", "lea_we", {15'd0, lea_we_o}, 16'd0);
        chk("R8", "ext_len", {14'd0, ext_len_o}, 16'd0);
    endtask

    task automatic t_idle_R9;
        logic [15:0] held;
        issue(8'b1_10_0_0001, 16'h2000, 1'b1, 2'd3);  // LEA S = U + 32
        chk("R9", "ea", ea_o, 16'h4020);
        held = ea_o;
        postbyte_i = 8'b0_00_00001; lea_i = 1'b1;     // valid_i stays low
        @(negedge clk);
        chk("R9", "valid", {15'd0, valid_o}, 16'd0);
        chk("R9", "lea_we", {15'd0, lea_we_o}, 16'd0);
        chk("R9", "ea hold", ea_o, held);
        lea_i = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_R1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_short_R2();
        t_const_R3();
        t_acc_R4();
        t_pcrel_R5();
        t_indirect_R6();
        t_lea_R7();
        t_reserved_R8();
        t_idle_R9();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule